// File: doc/BRIEF.md
# Ethernet Transmit Frame Generator

This block sits between a packet byte source and an 8-bit media adapter (MII or GMII) and turns each packet into a complete full-duplex Ethernet frame. When a packet is offered, the block first emits seven preamble bytes and a start delimiter. It then takes the packet bytes one per clock. Short packets get zero padding up to the 60-byte minimum. The frame ends with a 4-byte CRC-32 check value. Between frames the block holds its output idle for a fixed inter-frame gap.

The source offers bytes with a valid flag, marks the first and last byte of each packet, and advances only when `in_ready` is high. The block can also stamp its own station address into the source-address field of the frame. This happens only when the packet's first source-address byte, at offset 6 from the start of the packet, has the value 0xFF. That value is a marker that asks for the address to be filled in. Otherwise the packet's bytes are sent unchanged. Half-duplex operation, collision handling, flow control and statistics are outside this block.

Once a packet has started, the source is expected to supply a byte every cycle until its last byte. A frame on the wire cannot contain holes.

Top module: `eth_tx_framer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `tx_en` and `in_ready` are both 0.
- R2: Every frame opens with seven bytes of 0x55 followed by one byte of 0xD5 on `tx_data`, with `tx_en` high. The first packet byte is therefore accepted no sooner than 8 cycles after it is first offered.
- R3: Packet bytes outside the source-address window appear on `tx_data` in order, unchanged, one per cycle, in the cycle after they are accepted.
- R4: When a packet has fewer than 60 bytes, bytes of 0x00 follow it until 60 bytes have been sent after the start delimiter.
- R5: `in_ready` is high only while packet bytes are being taken. It is low during the preamble, the delimiter, the padding, the check value and the gap.
- R6: The last four bytes of a frame are the bitwise inverse of a CRC-32 (reflected polynomial 0xEDB88320, register preset to 0xFFFFFFFF, each byte fed least significant bit first). The CRC covers every byte after the delimiter, padding included. The check value is sent least significant byte first.
- R7: When packet byte 6 (counting from 0) is 0xFF, packet bytes 6 to 11 that exist are replaced by `cfg_src_addr[47:40]`, `[39:32]`, … `[7:0]` in that order.
- R8: When packet byte 6 is not 0xFF, no byte is replaced, including a 0xFF at any other offset.
- R9: At least 12 cycles with `tx_en` low separate the end of one frame from the start of the next, even when the next packet is already waiting.
- R10: A packet of 60 bytes or more gets no padding: the frame is 8 + N + 4 bytes long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_src_addr | input | 48 | Station address; bits 47:40 are sent first |
| in_data | input | 8 | Packet byte from the source |
| in_valid | input | 1 | `in_data` holds a byte |
| in_first | input | 1 | Current byte is the first of a packet |
| in_last | input | 1 | Current byte is the last of a packet |
| in_ready | output | 1 | Block takes the current byte at this edge |
| tx_data | output | 8 | Frame byte toward the media adapter |
| tx_en | output | 1 | `tx_data` is part of a frame |

## Verification
Two situations are hard to reach from the ports. The first is a packet that is already waiting while the block is still in its inter-frame gap. The bench reaches it by offering packets back to back with no idle time between driver calls, so every start after the first falls inside the gap. The second is the replacement marker sitting in a packet too short to cover the whole address window. A packet of 8 bytes with 0xFF at offset 6 exercises it: two bytes are replaced, then padding follows. A 64-byte packet with 0xFF at offset 7 only checks that the marker is recognised at offset 6 alone.

// File: rtl/eth_tx_pkg.sv
`timescale 1ns/1ps
// Shared types and the byte-wide CRC-32 step for the transmit frame generator.
package eth_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_GAP
    } tx_state_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;

    // Advance a reflected CRC-32 register by one byte, least significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            r = (r[0] ^ d[b]) ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/eth_tx_crc32.sv
`timescale 1ns/1ps
// CRC-32 accumulator. It is preset while `clear` is high and advances one byte
// per cycle while `update` is high. Assumes clear and update are never both high.
module eth_tx_crc32
    import eth_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        update,
    input  logic [7:0]  din,
    output logic [31:0] crc_q
);
    // Hold, preset or advance the running check value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc_q <= CRC_PRESET;
        end else if (update) begin
            crc_q <= crc32_step(crc_q, din);
        end
    end
endmodule

// File: rtl/eth_tx_src_subst.sv
`timescale 1ns/1ps
// Source-address replacement. At packet offset SA_OFFSET a 0xFF byte arms the
// replacement for SA_BYTES bytes starting there. Assumes `idx` is the offset of the
// byte currently on `din` and that `start` pulses before each packet.
module eth_tx_src_subst #(
    parameter int CNT_W     = 16,
    parameter int SA_OFFSET = 6,
    parameter int SA_BYTES  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  take,
    input  logic [CNT_W-1:0]      idx,
    input  logic [7:0]            din,
    input  logic [8*SA_BYTES-1:0] addr,
    output logic [7:0]            dout
);
    localparam int K_W = (SA_BYTES > 1) ? $clog2(SA_BYTES) : 1;
    localparam logic [CNT_W-1:0] WIN_LO = CNT_W'(SA_OFFSET);
    localparam logic [CNT_W-1:0] WIN_HI = CNT_W'(SA_OFFSET + SA_BYTES);

    logic [7:0]     addr_b [SA_BYTES];
    logic           armed_q;
    logic           in_win;
    logic           active;
    logic [K_W-1:0] k;

    // Split the address into bytes, the most significant one first on the wire.
    for (genvar g = 0; g < SA_BYTES; g++) begin : g_addr_bytes
        assign addr_b[g] = addr[8*(SA_BYTES-1-g) +: 8];
    end

    // Remember whether the marker byte was seen in this packet.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            armed_q <= 1'b0;
        end else if (take && idx == WIN_LO) begin
            armed_q <= (din == 8'hFF);
        end
    end

    // Choose the replacement byte or pass the packet byte through.
    always_comb begin
        in_win = (idx >= WIN_LO) && (idx < WIN_HI);
        k      = K_W'(idx - WIN_LO);
        active = in_win && ((idx == WIN_LO) ? (din == 8'hFF) : armed_q);
        dout   = active ? addr_b[k] : din;
    end

    // R8: without the marker no byte inside the window is altered.
    a_r8_no_subst_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && idx != WIN_LO && !armed_q) |-> (dout == din));
endmodule

// File: rtl/eth_tx_seq.sv
`timescale 1ns/1ps
// Frame sequencer. It walks through idle, preamble, packet, padding, check value and
// gap, and keeps the byte offset after the delimiter and a phase counter for the
// fixed-length parts. Assumes the source holds in_valid high from the first byte
// to the last byte of a packet.
module eth_tx_seq
    import eth_tx_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PH_W      = 4,
    parameter int PRE_LEN   = 7,
    parameter int MIN_BYTES = 60,
    parameter int GAP_LEN   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic             in_last,
    output logic             in_ready,
    output tx_state_e        st,
    output logic [CNT_W-1:0] idx,
    output logic [PH_W-1:0]  ph
);
    localparam logic [CNT_W-1:0] MIN_M1  = CNT_W'(MIN_BYTES - 1);
    localparam logic [PH_W-1:0]  PH_SFD  = PH_W'(PRE_LEN);
    localparam logic [PH_W-1:0]  PH_FCS  = PH_W'(3);
    localparam logic [PH_W-1:0]  PH_GAP  = PH_W'(GAP_LEN - 1);

    tx_state_e st_q;

    // Step the frame state, the byte offset and the phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            idx  <= '0;
            ph   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (in_valid && in_first) begin
                    st_q <= ST_PRE;
                    ph   <= '0;
                end
                ST_PRE: begin
                    ph <= ph + 1'b1;
                    if (ph == PH_SFD) begin
                        st_q <= ST_DATA;
                        idx  <= '0;
                    end
                end
                ST_DATA: if (in_valid) begin
                    idx <= idx + 1'b1;
                    if (in_last) begin
                        st_q <= (idx < MIN_M1) ? ST_PAD : ST_FCS;
                        ph   <= '0;
                    end
                end
                ST_PAD: begin
                    idx <= idx + 1'b1;
                    if (idx == MIN_M1) begin
                        st_q <= ST_FCS;
                        ph   <= '0;
                    end
                end
                ST_FCS: begin
                    ph <= ph + 1'b1;
                    if (ph == PH_FCS) begin
                        st_q <= ST_GAP;
                        ph   <= '0;
                    end
                end
                default: begin
                    ph <= ph + 1'b1;
                    if (ph == PH_GAP) begin
                        st_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign st       = st_q;
    assign in_ready = (st_q == ST_DATA);

    // R3: the source must not leave a hole inside a packet (input assumption).
    a_r3_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA) |-> in_valid);

    // R4: padding never carries the offset past the minimum size.
    a_r4_pad_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PAD) |-> (idx <= MIN_M1));
endmodule

// File: rtl/eth_tx_framer.sv
`timescale 1ns/1ps
// Ethernet transmit frame generator, top level. It selects the byte for each frame
// part, feeds the check-value accumulator and registers the output toward the media
// adapter. Assumes a full-duplex link and a source that never stalls mid-packet.
module eth_tx_framer
    import eth_tx_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PRE_LEN   = 7,
    parameter int MIN_BYTES = 60,
    parameter int GAP_LEN   = 12,
    parameter int SA_OFFSET = 6,
    parameter int SA_BYTES  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [8*SA_BYTES-1:0] cfg_src_addr,
    input  logic [7:0]            in_data,
    input  logic                  in_valid,
    input  logic                  in_first,
    input  logic                  in_last,
    output logic                  in_ready,
    output logic [7:0]            tx_data,
    output logic                  tx_en
);
    localparam int PH_MAX = (PRE_LEN > GAP_LEN) ? PRE_LEN : GAP_LEN;
    localparam int PH_W   = $clog2(PH_MAX + 1) + 1;

    tx_state_e        st;
    logic [CNT_W-1:0] idx;
    logic [PH_W-1:0]  ph;
    logic [7:0]       sub_byte;
    logic [7:0]       byte_c;
    logic             en_c;
    logic             take;
    logic [31:0]      crc_q;
    logic [7:0]       idle_cnt;

    eth_tx_seq #(
        .CNT_W(CNT_W), .PH_W(PH_W), .PRE_LEN(PRE_LEN),
        .MIN_BYTES(MIN_BYTES), .GAP_LEN(GAP_LEN)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_ready(in_ready), .st(st), .idx(idx), .ph(ph)
    );

    assign take = in_ready && in_valid;

    eth_tx_src_subst #(
        .CNT_W(CNT_W), .SA_OFFSET(SA_OFFSET), .SA_BYTES(SA_BYTES)
    ) u_subst (
        .clk(clk), .rst_n(rst_n), .start(st == ST_PRE), .take(take),
        .idx(idx), .din(in_data), .addr(cfg_src_addr), .dout(sub_byte)
    );

    eth_tx_crc32 u_crc (
        .clk(clk), .rst_n(rst_n), .clear(st == ST_PRE),
        .update(take || st == ST_PAD), .din(byte_c), .crc_q(crc_q)
    );

    // Pick the byte that belongs to the current part of the frame.
    always_comb begin
        byte_c = 8'h00;
        en_c   = 1'b0;
        unique case (st)
            ST_PRE:  begin byte_c = (ph == PH_W'(PRE_LEN)) ? 8'hD5 : 8'h55; en_c = 1'b1; end
            ST_DATA: begin byte_c = sub_byte; en_c = in_valid; end
            ST_PAD:  begin byte_c = 8'h00; en_c = 1'b1; end
            ST_FCS:  begin byte_c = ~crc_q[8*ph[1:0] +: 8]; en_c = 1'b1; end
            default: begin byte_c = 8'h00; en_c = 1'b0; end
        endcase
    end

    // Register the frame byte and its enable toward the media adapter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en   <= 1'b0;
            tx_data <= 8'h00;
        end else begin
            tx_en   <= en_c;
            tx_data <= byte_c;
        end
    end

    // Count idle output cycles, saturating, for the gap check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= 8'hFF;
        end else if (tx_en) begin
            idle_cnt <= 8'h00;
        end else if (idle_cnt != 8'hFF) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R2: a frame always opens with a preamble byte.
    a_r2_opens_with_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (tx_data == 8'h55));

    // R3: an accepted byte is on the wire in the following cycle.
    a_r3_accept_to_wire: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> tx_en);

    // R4: padding bytes are zero.
    a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAD) |=> (tx_data == 8'h00));

    // R6: the check value does not move while it is being sent.
    a_r6_crc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FCS && ph != '0) |-> $stable(crc_q));

    // R9: no frame starts before the gap has elapsed.
    a_r9_gap_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (idle_cnt >= 8'(GAP_LEN)));
endmodule

// File: tb/eth_tx_framer_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected frame bytes, the monitor compares them.
module eth_tx_framer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] cfg_src_addr = 48'h021A2B3C4D5E;
    logic [7:0]  in_data = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_first = 1'b0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic [7:0]  tx_data;
    logic        tx_en;

    int checks = 0;
    int fails  = 0;
    int sent   = 0;
    int nframes = 0;

    logic [7:0] exp_q[$];
    string      exp_tag_q[$];
    int         exp_len_q[$];
    string      len_tag_q[$];
    logic [7:0] rx_q[$];

    always #2.5 clk = ~clk;

    eth_tx_framer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_src_addr(cfg_src_addr), .in_data(in_data),
        .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .in_ready(in_ready), .tx_data(tx_data), .tx_en(tx_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (b[i]) begin
            for (int k = 0; k < 8; k++) begin
                if (c[0] ^ b[i][k]) c = (c >> 1) ^ 32'hEDB88320;
                else c = c >> 1;
            end
        end
        return c;
    endfunction

    // Build the packet and its expected frame, then drive it into the block.
    task automatic send_pkt(input int len, input bit mark, input logic [7:0] seed);
        logic [7:0] pk[$];
        logic [7:0] body[$];
        logic [31:0] fcs;
        int waits = 0;
        for (int i = 0; i < len; i++) begin
            logic [7:0] v = seed + 8'(i * 7);
            if (v == 8'hFF) v = 8'h12;
            if (i == 6) v = mark ? 8'hFF : 8'h34;
            if (i == 7 && !mark) v = 8'hFF;
            pk.push_back(v);
        end
        for (int i = 0; i < 7; i++) begin exp_q.push_back(8'h55); exp_tag_q.push_back("R2"); end
        exp_q.push_back(8'hD5); exp_tag_q.push_back("R2");
        for (int i = 0; i < len; i++) begin
            logic [7:0] v = pk[i];
            string t = "R3";
            if (i >= 6 && i <= 11) begin
                t = mark ? "R7" : "R8";
                if (mark) v = cfg_src_addr[8*(11-i) +: 8];
            end
            body.push_back(v); exp_q.push_back(v); exp_tag_q.push_back(t);
        end
        for (int i = len; i < 60; i++) begin
            body.push_back(8'h00); exp_q.push_back(8'h00); exp_tag_q.push_back("R4");
        end
        fcs = ~ref_crc(body);
        for (int i = 0; i < 4; i++) begin exp_q.push_back(fcs[8*i +: 8]); exp_tag_q.push_back("R6"); end
        exp_len_q.push_back(8 + body.size() + 4);
        len_tag_q.push_back(len < 60 ? "R4" : "R10");
        sent++;
        for (int i = 0; i < len; i++) begin
            in_data = pk[i]; in_first = (i == 0); in_last = (i == len - 1); in_valid = 1'b1;
            @(negedge clk);
            while (!in_ready) begin waits++; @(negedge clk); end
            if (i == 0) chk(waits >= 8, "R2", "first byte held back by preamble", waits, 8);
            @(posedge clk); #1;
        end
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b0, "R5", "ready low after last byte", in_ready, 0);
        @(posedge clk); #1;
    endtask

    // Compare one finished frame with the scoreboard.
    task automatic close_frame();
        int n;
        string lt;
        bit bad = 0;
        nframes++;
        if (exp_len_q.size() == 0) begin
            chk(0, "R3", "unexpected frame", rx_q.size(), 0);
            rx_q.delete();
            return;
        end
        n = exp_len_q.pop_front();
        lt = len_tag_q.pop_front();
        chk(rx_q.size() == n, lt, "frame length", rx_q.size(), n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] e = exp_q.pop_front();
            string t = exp_tag_q.pop_front();
            if (!bad && i < rx_q.size() && rx_q[i] != e) begin
                bad = 1;
                chk(0, t, $sformatf("frame %0d byte %0d", nframes, i), rx_q[i], e);
            end
        end
        if (!bad) chk(1, "R3", "frame content", 0, 0);
        rx_q.delete();
    endtask

    // Monitor: collect frame bytes and measure the gap between frames.
    int  idle = 1000;
    bit  prev_en = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_en) begin
                if (!prev_en && nframes > 0) chk(idle >= 12, "R9", "inter-frame gap", idle, 12);
                rx_q.push_back(tx_data);
                idle = 0;
            end else begin
                if (prev_en) close_frame();
                idle++;
            end
            prev_en = tx_en;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(tx_en == 1'b0, "R1", "tx_en in reset", tx_en, 0);
        chk(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(tx_en == 1'b0 && in_ready == 1'b0, "R1", "outputs after reset", {tx_en, in_ready}, 0);
        @(posedge clk); #1;
        send_pkt(60, 1, 8'h10);   // R7 R10: full address window, no padding
        send_pkt(14, 1, 8'h20);   // R4 R7: padded
        send_pkt(64, 0, 8'h30);   // R8 R10: marker at offset 7 only
        send_pkt(1,  0, 8'h40);   // R4: single byte packet
        send_pkt(8,  1, 8'h50);   // R7: window cut short by packet end
        send_pkt(61, 0, 8'h60);   // R10
        send_pkt(59, 1, 8'h70);   // R4: one pad byte
        while (nframes < sent) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(exp_len_q.size() == 0, "R3", "frames outstanding", exp_len_q.size(), 0);
        chk(tx_en == 1'b0, "R9", "idle after last frame", tx_en, 0);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog R3: actual=%0d expected=%0d frames", nframes, sent);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule